// File: doc/BRIEF.md
# Double-Buffered VGA Pixel Store

This block drives a 640x480 VGA monitor from a 50 MHz clock while a slow host draws the next picture in the background. It connects to two external 8-bit SRAM banks, and each bank has its own address, data and write-enable pins. At any moment one bank, the front, is scanned out. The other bank, the back, takes the host's writes. When the host asks for a flip, the two buses trade roles at the start of the next vertical blank, so a picture never changes part way down the screen.

A toggle flop halves the 50 MHz clock into a pixel-rate enable. Horizontal and vertical counters run off that enable. Both counters are shifted right by two bits before they address memory. Each stored byte therefore covers a 4x4 block of screen pixels, which gives a 160x120 image. A byte is read as 3-3-2 red/green/blue and widened to three 4-bit channels for a resistor-ladder DAC.

The host port uses one strobe, a 2-bit register selector and an 8-bit value. A pixel is written in three steps: latch the column, latch the row, then send the colour byte.

Top module: `vga_pageflip_fb`

## Requirements
- R1: While `rst_n` is low, and on the first clock after reset, all colour outputs are 0, both sync outputs are 1 and neither bank write enable is asserted. After reset, bank 0 is the front bank.
- R2: The pixel enable toggles on every clock, starting at 0 after reset. The scan counters advance only on clocks where it is 1, so each pixel lasts two clocks.
- R3: Host registers are selected by `host_sel`: 0 is the column (8 bits), 1 is the row (low 7 bits of `host_wdata`) and 2 is the colour byte. A strobe with selector 2 causes a one-clock write on the next clock. The write goes only to the back bank, with address {row, column} and address bits 16:15 at 0. The front bank's write enable stays low.
- R4: A line is `H_ACTIVE+H_FP+H_SYNC+H_BP` pixels long and a frame is `V_ACTIVE+V_FP+V_SYNC+V_BP` lines. `vga_hs_n` is low for pixel columns `H_ACTIVE+H_FP` up to but not including `H_ACTIVE+H_FP+H_SYNC`. `vga_vs_n` is low for the matching range of lines. Outputs are registered one pixel behind the counters.
- R5: The front bank's read address is {vertical count >> 2, horizontal count >> 2}.
- R6: A byte d is shown as red {d[7:5],d[7]}, green {d[4:2],d[4]} and blue {d[1:0],d[1:0]}.
- R7: Outside the active area, all colour outputs are 0.
- R8: A strobe with selector 3 requests a flip. The front and back banks trade places on the pixel where the scan enters line `V_ACTIVE`. Until then, writes keep going to the same back bank.
- R9: The column and row latches keep their values across colour writes, so a second colour strobe writes the same address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register strobe |
| host_sel | input | 2 | 0 column, 1 row, 2 colour byte, 3 flip request |
| host_wdata | input | 8 | Host register value |
| bank0_addr | output | 17 | Bank 0 address |
| bank0_wdata | output | 8 | Bank 0 write data |
| bank0_rdata | input | 8 | Bank 0 read data (asynchronous SRAM) |
| bank0_we | output | 1 | Bank 0 write enable, active high |
| bank1_addr | output | 17 | Bank 1 address |
| bank1_wdata | output | 8 | Bank 1 write data |
| bank1_rdata | input | 8 | Bank 1 read data (asynchronous SRAM) |
| bank1_we | output | 1 | Bank 1 write enable, active high |
| vga_r | output | 4 | Red level |
| vga_g | output | 4 | Green level |
| vga_b | output | 4 | Blue level |
| vga_hs_n | output | 1 | Horizontal sync, active low |
| vga_vs_n | output | 1 | Vertical sync, active low |

## Verification
Some properties are checked by assertions on every cycle. The two write enables are never high together. A colour strobe is always followed by exactly one bank write. The counters hold while the pixel enable is low. Colour is black whenever a sync pulse is active. The bank roles change only on the first pixel of the vertical blank.

Other behaviour only the bench's scenarios can show. Writes before a flip must stay invisible. The flipped picture must appear on the right frame with the right 4x4 binning. The 3-3-2 widening must be correct for extreme bytes. Repeated colour strobes must land on the retained address.

// File: rtl/vga_pageflip_fb.sv
module vga_pageflip_fb #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int BIN_SHIFT = 2,
  parameter int X_BITS   = 8,
  parameter int Y_BITS   = 7,
  parameter int MEM_AW   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [7:0]        host_wdata,
  output logic [MEM_AW-1:0] bank0_addr,
  output logic [7:0]        bank0_wdata,
  input  logic [7:0]        bank0_rdata,
  output logic              bank0_we,
  output logic [MEM_AW-1:0] bank1_addr,
  output logic [7:0]        bank1_wdata,
  input  logic [7:0]        bank1_rdata,
  output logic              bank1_we,
  output logic [3:0]        vga_r,
  output logic [3:0]        vga_g,
  output logic [3:0]        vga_b,
  output logic              vga_hs_n,
  output logic              vga_vs_n
);
  localparam int HT  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int VT  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HCW = $clog2(HT);
  localparam int VCW = $clog2(VT);
  localparam int HS0 = H_ACTIVE + H_FP;
  localparam int HS1 = HS0 + H_SYNC;
  localparam int VS0 = V_ACTIVE + V_FP;
  localparam int VS1 = VS0 + V_SYNC;

  logic              pix_en, front, swap_pend, wr_go;
  logic [HCW-1:0]    hcnt;
  logic [VCW-1:0]    vcnt;
  logic [X_BITS-1:0] x_q;
  logic [Y_BITS-1:0] y_q;
  logic [7:0]        d_q;

  wire line_end  = hcnt == HCW'(HT - 1);
  wire active    = (hcnt < HCW'(H_ACTIVE)) && (vcnt < VCW'(V_ACTIVE));
  wire hs_on     = (hcnt >= HCW'(HS0)) && (hcnt < HCW'(HS1));
  wire vs_on     = (vcnt >= VCW'(VS0)) && (vcnt < VCW'(VS1));
  wire enter_vbl = pix_en && line_end && (vcnt == VCW'(V_ACTIVE - 1));

  wire [X_BITS-1:0] dx = X_BITS'(hcnt >> BIN_SHIFT);
  wire [Y_BITS-1:0] dy = Y_BITS'(vcnt >> BIN_SHIFT);
  wire [MEM_AW-1:0] disp_addr = MEM_AW'({dy, dx});
  wire [MEM_AW-1:0] wr_addr   = MEM_AW'({y_q, x_q});
  wire [7:0]        pix       = front ? bank1_rdata : bank0_rdata;

  assign bank0_addr  = front ? wr_addr : disp_addr;
  assign bank1_addr  = front ? disp_addr : wr_addr;
  assign bank0_wdata = d_q;
  assign bank1_wdata = d_q;
  assign bank0_we    = wr_go & front;
  assign bank1_we    = wr_go & ~front;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_en <= 1'b0; hcnt <= '0; vcnt <= '0;
      front <= 1'b0; swap_pend <= 1'b0; wr_go <= 1'b0;
      x_q <= '0; y_q <= '0; d_q <= '0;
      vga_r <= '0; vga_g <= '0; vga_b <= '0;
      vga_hs_n <= 1'b1; vga_vs_n <= 1'b1;
    end else begin
      pix_en <= ~pix_en;
      if (pix_en) begin
        vga_r    <= active ? {pix[7:5], pix[7]} : 4'd0;
        vga_g    <= active ? {pix[4:2], pix[4]} : 4'd0;
        vga_b    <= active ? {pix[1:0], pix[1:0]} : 4'd0;
        vga_hs_n <= ~hs_on;
        vga_vs_n <= ~vs_on;
        if (line_end) begin
          hcnt <= '0;
          vcnt <= (vcnt == VCW'(VT - 1)) ? '0 : vcnt + 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
      if (enter_vbl && swap_pend) begin
        front     <= ~front;
        swap_pend <= 1'b0;
      end
      wr_go <= host_we && (host_sel == 2'd2);
      if (host_we) begin
        case (host_sel)
          2'd0: x_q <= host_wdata[X_BITS-1:0];
          2'd1: y_q <= host_wdata[Y_BITS-1:0];
          2'd2: d_q <= host_wdata;
          default: swap_pend <= 1'b1;
        endcase
      end
    end
  end

  p_one_bank_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank0_we && bank1_we));

  p_write_follows_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == 2'd2) |=> (bank0_we || bank1_we));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(hcnt) && $stable(vcnt)));

  p_black_in_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vga_hs_n || !vga_vs_n) |-> ({vga_r, vga_g, vga_b} == 12'd0));

  p_flip_at_vblank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (front != $past(front)) |-> (hcnt == '0 && vcnt == VCW'(V_ACTIVE)));
endmodule

// File: tb/tb_vga_pageflip_fb.sv
module tb_vga_pageflip_fb;
  localparam int HA = 16, HFP = 2, HSY = 3, HBP = 3;
  localparam int VA = 12, VFP = 1, VSY = 2, VBP = 2;
  localparam int HT = HA + HFP + HSY + HBP;
  localparam int VT = VA + VFP + VSY + VBP;
  localparam int FRAME_CLKS = 2 * HT * VT;

  logic clk = 0, rst_n = 0, host_we = 0;
  logic [1:0] host_sel = 0;
  logic [7:0] host_wdata = 0;
  logic [16:0] bank0_addr, bank1_addr;
  logic [7:0] bank0_wdata, bank1_wdata, bank0_rdata, bank1_rdata;
  logic bank0_we, bank1_we, vga_hs_n, vga_vs_n;
  logic [3:0] vga_r, vga_g, vga_b;

  always #10 clk = ~clk;

  vga_pageflip_fb #(.H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
                    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata),
    .bank0_addr(bank0_addr), .bank0_wdata(bank0_wdata), .bank0_rdata(bank0_rdata),
    .bank0_we(bank0_we),
    .bank1_addr(bank1_addr), .bank1_wdata(bank1_wdata), .bank1_rdata(bank1_rdata),
    .bank1_we(bank1_we),
    .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b),
    .vga_hs_n(vga_hs_n), .vga_vs_n(vga_vs_n));

  logic [7:0] sram0 [0:32767];
  logic [7:0] sram1 [0:32767];
  logic [7:0] shadow [0:65535];
  assign bank0_rdata = sram0[bank0_addr[14:0]];
  assign bank1_rdata = sram1[bank1_addr[14:0]];
  always @(posedge clk) begin
    if (bank0_we) sram0[bank0_addr[14:0]] <= bank0_wdata;
    if (bank1_we) sram1[bank1_addr[14:0]] <= bank1_wdata;
  end

  int vectors = 0, errors = 0;
  bit done = 0;

  int m_h, m_v, m_x, m_y;
  bit m_pe, m_front, m_pend, m_wp;
  logic [7:0] m_d, px;
  logic [3:0] e_r, e_g, e_b;
  bit e_hs, e_vs;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pe = 0; m_h = 0; m_v = 0; m_front = 0; m_pend = 0; m_wp = 0;
      m_x = 0; m_y = 0; m_d = 0;
      e_r = 0; e_g = 0; e_b = 0; e_hs = 1; e_vs = 1;
    end else begin
      bit of;
      of = m_front;
      if (m_pe) begin
        if (m_h < HA && m_v < VA) begin
          px = shadow[(of ? 32768 : 0) + (m_v / 4) * 256 + (m_h / 4)];
          e_r = {px[7:5], px[7]}; e_g = {px[4:2], px[4]}; e_b = {px[1:0], px[1:0]};
        end else begin
          e_r = 0; e_g = 0; e_b = 0;
        end
        e_hs = !(m_h >= HA + HFP && m_h < HA + HFP + HSY);
        e_vs = !(m_v >= VA + VFP && m_v < VA + VFP + VSY);
        if (m_h == HT - 1) begin
          m_h = 0;
          if (m_pend && m_v == VA - 1) begin m_front = !m_front; m_pend = 0; end
          m_v = (m_v == VT - 1) ? 0 : m_v + 1;
        end else m_h = m_h + 1;
      end
      if (m_wp) shadow[(of ? 0 : 32768) + m_y * 256 + m_x] = m_d;
      m_wp = host_we && host_sel == 2;
      if (host_we) begin
        case (host_sel)
          0: m_x = host_wdata;
          1: m_y = host_wdata[6:0];
          2: m_d = host_wdata;
          default: m_pend = 1;
        endcase
      end
      m_pe = !m_pe;
    end
  end

  task automatic cmp(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        cmp("R1 colour in reset", {vga_r, vga_g, vga_b}, 0);
        cmp("R1 sync in reset", {vga_hs_n, vga_vs_n}, 2'b11);
        cmp("R1 write enables in reset", {bank0_we, bank1_we}, 0);
      end else begin
        cmp((m_h < HA && m_v < VA) ? "R5 R6 colour" : "R7 blank colour",
            {vga_r, vga_g, vga_b}, {e_r, e_g, e_b});
        cmp("R2 R4 hsync", vga_hs_n, e_hs);
        cmp("R4 vsync", vga_vs_n, e_vs);
        cmp("R3 R8 bank0 we", bank0_we, m_wp && m_front);
        cmp("R3 R8 bank1 we", bank1_we, m_wp && !m_front);
        if (m_wp) begin
          cmp("R3 R9 write address", m_front ? bank0_addr : bank1_addr, m_y * 256 + m_x);
          cmp("R3 write data", m_front ? bank0_wdata : bank1_wdata, m_d);
        end
      end
    end
  end

  task automatic op(input int sel, input int val);
    @(negedge clk);
    host_we = 1; host_sel = 2'(sel); host_wdata = 8'(val);
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic pixel(input int x, input int y, input int d);
    op(0, x); op(1, y); op(2, d);
  endtask

  initial begin
    for (int i = 0; i < 32768; i++) begin sram0[i] = 0; sram1[i] = 0; end
    for (int i = 0; i < 65536; i++) shadow[i] = 0;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    for (int y = 0; y < 3; y++)
      for (int x = 0; x < 4; x++) pixel(x, y, (y * 4 + x) * 29 + 5);
    pixel(3, 2, 8'hFF);
    op(2, 8'h00);
    op(2, 8'hE3);
    repeat (FRAME_CLKS / 2) @(negedge clk);
    op(3, 0);
    pixel(1, 1, 8'h1C);
    repeat (2 * FRAME_CLKS) @(negedge clk);
    for (int y = 0; y < 3; y++)
      for (int x = 0; x < 4; x++) pixel(x, y, 8'hFF - (x * 50 + y * 7));
    op(3, 0);
    repeat (FRAME_CLKS / 3) @(negedge clk);
    pixel(0, 0, 8'h03);
    pixel(2, 1, 8'hE0);
    repeat (2 * FRAME_CLKS) @(negedge clk);
    op(3, 0);
    repeat (FRAME_CLKS + 50) @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule